// File: doc/BRIEF.md
# Local Interrupt Status and Enable Controller

This block gathers single-cycle event pulses from on-board sources into sticky status flags. Each flag has an enable bit at the same position in a second register. The enabled flags are OR-reduced, qualified by a global enable bit, and drive one registered, active-low interrupt line toward a host bridge.

The global enable bit sits in the status register, at the top bit position. The auto-clear control bit sits at the same position in the enable register. When auto-clear is on, a read of the status register returns its current contents and also drops the global enable. Software can then service the sources and re-arm everything with one write of the status register. Flags clear only when software writes zero to their bit. Writing one to a flag bit leaves it as it is.

Both registers sit behind a plain 32-bit access port made of an address, a write strobe with write data, and a read strobe with combinational read data. By default the status register is at address 0 and the enable register at address 1. Other addresses read as zero and ignore writes.

Top module: `irq_stat_en_ctrl`

## Requirements
- R1: While reset is asserted, every status flag, every enable bit, the auto-clear bit and the global enable are cleared, and `irq_n_o` is 1.
- R2: A 1 on `evt_i[i]` for one cycle sets status bit i at that clock edge. The bit stays 1 after the event input returns to 0.
- R3: A write to the status register clears each flag whose written bit is 0 and leaves unchanged each flag whose written bit is 1.
- R4: If an event for bit i arrives in the same cycle as a status write with bit i at 0, flag i ends at 1.
- R5: Status bit GIE_BIT (31 by default) is the global enable. It takes the written value directly and reads back at that position.
- R6: The enable register holds enables at bits N_SRC-1..0 and the auto-clear control at bit GIE_BIT. All other bits of both registers read as 0.
- R7: `irq_n_o` is 0 in the cycle after one in which the global enable is 1 and some flag and its enable are both 1. Otherwise it is 1 in that next cycle, so it deasserts one cycle after the condition is removed.
- R8: With auto-clear at 1, a status read returns the global enable as it was before the read and clears it at that edge, so the next read shows 0 at bit GIE_BIT.
- R9: With auto-clear at 0, a status read leaves the global enable unchanged.
- R10: Writes to any address other than the two register addresses change no state, and reads of such addresses return 0.
- R11: `reg_rdata_o` is 0 whenever `reg_rd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | Event pulses, one per source |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Read data, valid while the read strobe is high |
| irq_n_o | output | 1 | Registered active-low interrupt |

## Verification
The bench builds the block with N_SRC=4, GIE_BIT=31 and ADDR_W=2. This leaves two unmapped addresses for the R10 checks. With four sources, every flag pattern can be crossed with every enable pattern and both global enable values, which gives 512 cases. The interrupt output and the status read-back are each checked in every case against values computed arithmetically. Separate directed steps cover the same-cycle set-versus-clear race, the auto-clear read sequence with auto-clear on and off, and the one-cycle deassert delay.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
   localparam int REG_W = 32;

   typedef struct packed {
      logic wr_stat;
      logic wr_enab;
      logic rd_stat;
      logic rd_enab;
      logic hit;
   } irqc_dec_t;
endpackage

// File: rtl/irqc_decode.sv
`timescale 1ns/1ps
module irqc_decode
   import irqc_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int STAT_ADDR = 0,
   parameter int ENAB_ADDR = 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   output irqc_dec_t         dec_o
);
   localparam logic [ADDR_W-1:0] S_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] E_A = ADDR_W'(ENAB_ADDR);

   logic is_stat, is_enab;

   always_comb begin
      is_stat       = (addr_i == S_A);
      is_enab       = (addr_i == E_A);
      dec_o.wr_stat = wr_i & is_stat;
      dec_o.wr_enab = wr_i & is_enab;
      dec_o.rd_stat = rd_i & is_stat;
      dec_o.rd_enab = rd_i & is_enab;
      dec_o.hit     = is_stat | is_enab;
   end
endmodule

// File: rtl/irqc_flag_bank.sv
`timescale 1ns/1ps
module irqc_flag_bank #(
   parameter int N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_i,
   input  logic             clr_we_i,
   input  logic [N_SRC-1:0] wbits_i,
   output logic [N_SRC-1:0] flags_o
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      logic bit_q;
      // a new event outranks a software clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (evt_i[i])
            bit_q <= 1'b1;
         else if (clr_we_i && !wbits_i[i])
            bit_q <= 1'b0;
      end
      assign flags_o[i] = bit_q;
   end
endmodule

// File: rtl/irqc_ctrl.sv
`timescale 1ns/1ps
module irqc_ctrl
   import irqc_pkg::*;
#(
   parameter int N_SRC   = 8,
   parameter int GIE_BIT = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  irqc_dec_t        dec_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [N_SRC-1:0] en_o,
   output logic             auto_o,
   output logic             gie_o
);
   logic [N_SRC-1:0] en_q;
   logic             auto_q, gie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         auto_q <= 1'b0;
      end else if (dec_i.wr_enab) begin
         en_q   <= wdata_i[N_SRC-1:0];
         auto_q <= wdata_i[GIE_BIT];
      end
   end

   // explicit write beats the read side effect
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gie_q <= 1'b0;
      else if (dec_i.wr_stat)
         gie_q <= wdata_i[GIE_BIT];
      else if (dec_i.rd_stat && auto_q)
         gie_q <= 1'b0;
   end

   assign en_o   = en_q;
   assign auto_o = auto_q;
   assign gie_o  = gie_q;
endmodule

// File: rtl/irqc_out.sv
`timescale 1ns/1ps
module irqc_out #(
   parameter int N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] flags_i,
   input  logic [N_SRC-1:0] en_i,
   input  logic             gie_i,
   output logic             irq_n_o
);
   logic any_req, irq_n_q;

   assign any_req = gie_i & (|(flags_i & en_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_q <= 1'b1;
      else        irq_n_q <= ~any_req;
   end

   assign irq_n_o = irq_n_q;
endmodule

// File: rtl/irq_stat_en_ctrl.sv
`timescale 1ns/1ps
module irq_stat_en_ctrl
   import irqc_pkg::*;
#(
   parameter int N_SRC     = 8,
   parameter int GIE_BIT   = 31,
   parameter int ADDR_W    = 2,
   parameter int STAT_ADDR = 0,
   parameter int ENAB_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  evt_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [31:0]       reg_wdata_i,
   input  logic              reg_rd_i,
   output logic [31:0]       reg_rdata_o,
   output logic              irq_n_o
);
   if (N_SRC < 1 || N_SRC > GIE_BIT) begin : g_bad_nsrc
      $error("N_SRC must lie in 1..GIE_BIT");
   end
   if (GIE_BIT >= REG_W) begin : g_bad_gie
      $error("GIE_BIT must fit in the register word");
   end
   if (STAT_ADDR == ENAB_ADDR || STAT_ADDR >= (1 << ADDR_W) || ENAB_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register addresses must be distinct and reachable");
   end

   irqc_dec_t        dec;
   logic [N_SRC-1:0] flag_q, en_q;
   logic             auto_q, gie_q;
   logic [REG_W-1:0] stat_word, enab_word;

   irqc_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .ENAB_ADDR(ENAB_ADDR)) u_dec (
      .addr_i (reg_addr_i),
      .wr_i   (reg_wr_i),
      .rd_i   (reg_rd_i),
      .dec_o  (dec)
   );

   irqc_flag_bank #(.N_SRC(N_SRC)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i),
      .clr_we_i (dec.wr_stat),
      .wbits_i  (reg_wdata_i[N_SRC-1:0]),
      .flags_o  (flag_q)
   );

   irqc_ctrl #(.N_SRC(N_SRC), .GIE_BIT(GIE_BIT)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .dec_i   (dec),
      .wdata_i (reg_wdata_i),
      .en_o    (en_q),
      .auto_o  (auto_q),
      .gie_o   (gie_q)
   );

   irqc_out #(.N_SRC(N_SRC)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flag_q),
      .en_i    (en_q),
      .gie_i   (gie_q),
      .irq_n_o (irq_n_o)
   );

   always_comb begin
      stat_word                = '0;
      enab_word                = '0;
      stat_word[N_SRC-1:0]     = flag_q;
      stat_word[GIE_BIT]       = gie_q;
      enab_word[N_SRC-1:0]     = en_q;
      enab_word[GIE_BIT]       = auto_q;
      reg_rdata_o              = '0;
      if (dec.rd_stat)      reg_rdata_o = stat_word;
      else if (dec.rd_enab) reg_rdata_o = enab_word;
   end
endmodule

// File: rtl/irqc_chk.sv
`timescale 1ns/1ps
module irqc_chk #(
   parameter int N_SRC     = 8,
   parameter int ADDR_W    = 2,
   parameter int STAT_ADDR = 0,
   parameter int ENAB_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC-1:0]  evt,
   input logic [ADDR_W-1:0] addr,
   input logic              wr,
   input logic              rd,
   input logic [31:0]       rdata,
   input logic [N_SRC-1:0]  flags,
   input logic [N_SRC-1:0]  en,
   input logic              auto_clr,
   input logic              gie,
   input logic              irq_n
);
   logic at_stat, at_enab, wr_stat, rd_stat, wr_other;
   assign at_stat  = (addr == ADDR_W'(STAT_ADDR));
   assign at_enab  = (addr == ADDR_W'(ENAB_ADDR));
   assign wr_stat  = wr && at_stat;
   assign rd_stat  = rd && at_stat;
   assign wr_other = wr && !at_stat && !at_enab;

   p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> irq_n);

   p_event_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((flags & $past(evt)) == $past(evt)));

   p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((flags & $past(flags)) == $past(flags)));

   p_irq_assert_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gie && |(flags & en)) |=> !irq_n);

   p_irq_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(gie && |(flags & en)) |=> irq_n);

   p_auto_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && auto_clr && !wr_stat) |=> !gie);

   p_gie_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stat && !(rd_stat && auto_clr)) |=> $stable(gie));

   p_other_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_other |=> ($stable(en) && $stable(auto_clr)));

   p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> (rdata == 32'h0));
endmodule

bind irq_stat_en_ctrl irqc_chk #(
   .N_SRC(N_SRC), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .ENAB_ADDR(ENAB_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt      (evt_i),
   .addr     (reg_addr_i),
   .wr       (reg_wr_i),
   .rd       (reg_rd_i),
   .rdata    (reg_rdata_o),
   .flags    (flag_q),
   .en       (en_q),
   .auto_clr (auto_q),
   .gie      (gie_q),
   .irq_n    (irq_n_o)
);

// File: tb/irq_stat_en_ctrl_test.sv
`timescale 1ns/1ps
module irq_stat_en_ctrl_test;
   localparam int NS = 4;
   localparam int AW = 2;
   localparam logic [AW-1:0] A_STAT = 2'd0;
   localparam logic [AW-1:0] A_ENAB = 2'd1;
   localparam logic [31:0]   GBIT   = 32'h8000_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] evt = '0;
   logic [AW-1:0] addr = '0;
   logic          wr = 1'b0;
   logic [31:0]   wdata = '0;
   logic          rd = 1'b0;
   logic [31:0]   rdata;
   logic          irq_n;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_stat_en_ctrl #(.N_SRC(NS), .GIE_BIT(31), .ADDR_W(AW), .STAT_ADDR(0), .ENAB_ADDR(1)) uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr_i(addr), .reg_wr_i(wr),
      .reg_wdata_i(wdata), .reg_rd_i(rd), .reg_rdata_o(rdata), .irq_n_o(irq_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic pulse(input logic [NS-1:0] p);
      @(negedge clk);
      evt = p;
      @(negedge clk);
      evt = '0;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      check("R1 irq in reset", {31'b0, irq_n}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 idle bus", rdata, 32'h0);
      rd_reg(A_STAT, v); check("R1 status after reset", v, 32'h0);
      rd_reg(A_ENAB, v); check("R1 enable after reset", v, 32'h0);

      // exhaustive sweep R2 R3 R5 R7
      for (int f = 0; f < 16; f++) begin
         for (int e = 0; e < 16; e++) begin
            for (int g = 0; g < 2; g++) begin
               wr_reg(A_STAT, 32'h0);
               pulse(NS'(f));
               wr_reg(A_ENAB, 32'(e));
               wr_reg(A_STAT, (g != 0 ? GBIT : 32'h0) | 32'hF);
               @(negedge clk);
               check("R7 sweep irq", {31'b0, irq_n},
                     {31'b0, !(((f & e) != 0) && (g != 0))});
               rd_reg(A_STAT, v);
               check("R2 R3 R5 sweep status", v, 32'(f) | (g != 0 ? GBIT : 32'h0));
            end
         end
      end

      // R3 selective clear
      wr_reg(A_STAT, 32'h0);
      pulse(4'hF);
      wr_reg(A_STAT, 32'h0000_000A);
      rd_reg(A_STAT, v); check("R3 selective clear", v, 32'h0000_000A);

      // R4 set beats clear
      wr_reg(A_STAT, 32'h0);
      @(negedge clk);
      addr = A_STAT; wdata = 32'h0; wr = 1'b1; evt = 4'h1;
      @(negedge clk);
      wr = 1'b0; evt = '0;
      rd_reg(A_STAT, v); check("R4 set wins", v, 32'h0000_0001);

      // R6 enable layout
      wr_reg(A_ENAB, 32'hFFFF_FFFF);
      rd_reg(A_ENAB, v); check("R6 enable readback", v, 32'h8000_000F);

      // R8 auto-clear read
      wr_reg(A_STAT, 32'h0);
      pulse(4'h2);
      wr_reg(A_ENAB, GBIT | 32'h2);
      wr_reg(A_STAT, GBIT | 32'hF);
      @(negedge clk);
      check("R8 irq before read", {31'b0, irq_n}, 32'h0);
      rd_reg(A_STAT, v); check("R8 first read pre-clear", v, GBIT | 32'h2);
      rd_reg(A_STAT, v); check("R8 second read cleared", v, 32'h2);
      check("R8 irq released", {31'b0, irq_n}, 32'h1);

      // R9 auto-clear off
      wr_reg(A_ENAB, 32'h2);
      wr_reg(A_STAT, GBIT | 32'hF);
      rd_reg(A_STAT, v); check("R9 first read", v, GBIT | 32'h2);
      rd_reg(A_STAT, v); check("R9 gie kept", v, GBIT | 32'h2);
      check("R9 irq still active", {31'b0, irq_n}, 32'h0);

      // R7 one cycle deassert delay
      wr_reg(A_STAT, GBIT);
      check("R7 irq held one cycle", {31'b0, irq_n}, 32'h0);
      @(negedge clk);
      check("R7 irq released next cycle", {31'b0, irq_n}, 32'h1);

      // R10 unmapped addresses
      pulse(4'h5);
      wr_reg(2'd2, 32'hFFFF_FFFF);
      wr_reg(2'd3, 32'h0);
      rd_reg(A_ENAB, v); check("R10 enable untouched", v, 32'h2);
      rd_reg(A_STAT, v); check("R10 status untouched", v, GBIT | 32'h5);
      rd_reg(2'd3, v);   check("R10 unmapped read", v, 32'h0);
      @(negedge clk);
      check("R11 no strobe no data", rdata, 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule